// File: doc/BRIEF.md
# Logic Analyzer Trigger and Capture Engine

This block is an on-chip capture engine for debug. Four match units each compare a trigger vector against a programmed value. Their results feed a trigger stage that runs in one of two ways. In flat mode the enabled results are joined by a single AND or a single OR, and the whole result can be inverted. In sequencer mode the results pass through an ordered chain of up to four levels. When the trigger fires, samples are written into an internal buffer. A sample is either the data vector or, as an option, the trigger vector itself.

Capture is started by one of two arm commands. One waits for the trigger, and the other stores every cycle. A stop command ends capture. With the trigger-armed command, one of two capture modes applies. Window mode stores one run of samples after the trigger and then finishes. N-samples mode stores a run on every trigger. The write pointer never passes the buffer depth. After capture, software reads the samples back in the order they were taken, through an address-in, data-out port. A small write port loads the match values, the control word and the run length.

Top module: `ela_capture`

## Requirements
- R1: A match unit register is written at addresses 0 to 3 (one per unit). Its value sits in the low TRIG_W bits. Its relation code sits in the next two bits: 0 = equal, 1 = not equal, 2 = trigger less than value, 3 = trigger greater than value. Its enable bit sits just above the relation code.
- R2: The control word is at address 4, with bit 0 = 0 selecting flat mode. In flat mode, `trig_hit_o` is computed from the enabled units only, as follows. Control bit 1 selects the join: 0 gives AND, where disabled units count as true. 1 gives OR, where disabled units count as false. Control bit 2 inverts the result.
- R3: Control bit 0 = 1 selects sequencer mode. Bits [6:5] hold the last level index, and level l uses the unit index in bits [8+2l:7+2l]. The unit enable bits are ignored here. The level advances on the first waiting cycle in which its unit matches. The trigger fires in the cycle that the last level's unit matches, and the level then returns to 0.
- R4: Window mode is control bit 3 = 0. The sample in the firing cycle and the next L-1 cycles are stored, where L is the length register at address 5 (0 counts as 1). Then `done_o` sets and no further samples are stored.
- R5: N-samples mode is control bit 3 = 1. Each trigger stores L samples, starting with the firing cycle. A trigger that arrives during a run is ignored. After the run, the block waits for the next trigger.
- R6: `count_o` never exceeds DEPTH. When the buffer is full, `done_o` sets and storing stops, whatever the mode.
- R7: `stop_i` sets `done_o` at the next edge and ends storing. `stop_i` takes priority over both arm commands.
- R8: `arm_trig_i` and `arm_free_i` clear the write pointer, the sequencer level and `done_o`. `arm_trig_i` waits for the trigger and wins if both are asserted. `arm_free_i` stores every cycle, starting with the cycle after the arm.
- R9: Control bit 4 = 1 stores the trigger vector, zero-extended, in place of `data_i`.
- R10: `rd_data_o` at address k returns the k-th stored sample since the last arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| arm_trig_i | input | 1 | Arm and wait for the trigger |
| arm_free_i | input | 1 | Arm and store every cycle |
| stop_i | input | 1 | Stop capture |
| trig_i | input | TRIG_W | Trigger vector |
| data_i | input | DATA_W | Data vector |
| rd_addr_i | input | $clog2(DEPTH) | Readout address |
| rd_data_o | output | DATA_W | Stored sample at the readout address |
| trig_hit_o | output | 1 | Trigger condition in this cycle |
| count_o | output | $clog2(DEPTH)+1 | Number of stored samples |
| done_o | output | 1 | Capture finished |

## Verification
The bench builds the block with DEPTH = 8 and 8-bit trigger and data vectors. With a depth this small, a free-running capture fills the buffer within a few cycles. It also lets an N-samples run be clipped partway through, so the full-buffer stop is reached in both capture modes. The random phase draws match values and trigger values from 0 to 3, which makes equal, less-than and greater-than hits frequent under every join and inversion. Directed sequences cover the ordered sequencer, including out-of-order matches that must not advance it.

// File: rtl/ela_pkg.sv
package ela_pkg;
  localparam int N_MATCH = 4;
  localparam int N_LVL   = 4;
  localparam int SEL_W   = $clog2(N_MATCH);
  localparam int LVL_W   = $clog2(N_LVL);

  typedef enum logic [1:0] {REL_EQ, REL_NE, REL_LT, REL_GT} rel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST, ST_FREE} cap_st_e;

  typedef struct packed {
    logic [N_LVL*SEL_W-1:0] lvl_sel;
    logic [LVL_W-1:0]       last_lvl;
    logic                   store_trig;
    logic                   nsamp;
    logic                   invert;
    logic                   use_or;
    logic                   seq_mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ela_match_unit.sv
module ela_match_unit import ela_pkg::*; #(
  parameter int TRIG_W = 8
) (
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [TRIG_W-1:0] value_i,
  input  rel_e              rel_i,
  output logic              hit_o
);
  always_comb begin
    unique case (rel_i)
      REL_EQ: hit_o = (trig_i == value_i);
      REL_NE: hit_o = (trig_i != value_i);
      REL_LT: hit_o = (trig_i <  value_i);
      REL_GT: hit_o = (trig_i >  value_i);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ela_trig_comb.sv
module ela_trig_comb import ela_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wait_i,
  input  logic [N_MATCH-1:0] hit_i,
  input  logic [N_MATCH-1:0] en_i,
  input  ctrl_t              ctrl_i,
  output logic               trig_o
);
  logic [LVL_W-1:0] lvl_q;
  logic [SEL_W-1:0] cur_sel;
  logic             cur_hit, is_last, flat_res;

  assign flat_res = (ctrl_i.use_or ? |(hit_i & en_i) : &(hit_i | ~en_i)) ^ ctrl_i.invert;
  assign cur_sel  = ctrl_i.lvl_sel[lvl_q*SEL_W +: SEL_W];
  assign cur_hit  = hit_i[cur_sel];
  assign is_last  = (lvl_q >= ctrl_i.last_lvl);
  assign trig_o   = ctrl_i.seq_mode ? (cur_hit && is_last) : flat_res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  lvl_q <= '0;
    else if (clr_i)                               lvl_q <= '0;
    else if (wait_i && ctrl_i.seq_mode && cur_hit) lvl_q <= is_last ? '0 : lvl_q + 1'b1;
  end

  // sequencer moves by at most one level, or restarts
  p_lvl_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lvl_q == $past(lvl_q) || lvl_q == $past(lvl_q) + 1'b1 || lvl_q == '0));
  p_arm_lvl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> lvl_q == '0);
endmodule

// File: rtl/ela_capture_ctrl.sv
module ela_capture_ctrl import ela_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_trig_i,
  input  logic             arm_free_i,
  input  logic             stop_i,
  input  logic             fire_i,
  input  logic             nsamp_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             we_o,
  output logic             wait_o,
  output logic             clr_o,
  output logic [AW:0]      ptr_o,
  output logic             done_o
);
  cap_st_e          st_q;
  logic [AW:0]      ptr_q;
  logic [LEN_W-1:0] rem_q;
  logic             done_q, arm_any, last_slot;

  assign arm_any   = arm_trig_i | arm_free_i;
  assign clr_o     = arm_any & ~stop_i;
  assign wait_o    = (st_q == ST_WAIT);
  assign last_slot = (ptr_q == (AW+1)'(DEPTH-1));
  assign we_o      = !stop_i && !arm_any &&
                     (st_q == ST_FREE || st_q == ST_BURST || (st_q == ST_WAIT && fire_i));
  assign ptr_o     = ptr_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ptr_q <= '0; rem_q <= '0; done_q <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE; done_q <= 1'b1;
    end else if (arm_any) begin
      st_q <= arm_trig_i ? ST_WAIT : ST_FREE;
      ptr_q <= '0; rem_q <= '0; done_q <= 1'b0;
    end else if (we_o) begin
      ptr_q <= ptr_q + 1'b1;
      if (last_slot) begin
        st_q <= ST_IDLE; done_q <= 1'b1;
      end else begin
        unique case (st_q)
          ST_WAIT: begin
            if (len_i <= LEN_W'(1)) begin
              st_q <= nsamp_i ? ST_WAIT : ST_IDLE;
              done_q <= !nsamp_i;
            end else begin
              st_q <= ST_BURST; rem_q <= len_i - 1'b1;
            end
          end
          ST_BURST: begin
            if (rem_q == LEN_W'(1)) begin
              st_q <= nsamp_i ? ST_WAIT : ST_IDLE;
              done_q <= !nsamp_i;
            end
            rem_q <= rem_q - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= (AW+1)'(DEPTH));
  p_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> st_q == ST_IDLE);
  p_stop_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> done_q && $stable(ptr_q));
  p_arm_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_any && !stop_i) |=> (ptr_q == '0 && !done_q));
  p_burst_left_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_BURST |-> rem_q != '0);
endmodule

// File: rtl/ela_sample_buf.sv
module ela_sample_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ela_capture.sv
module ela_capture import ela_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int TRIG_W = 8,
  parameter int DEPTH  = 16,
  parameter int CFG_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LEN_W = CFG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              arm_trig_i,
  input  logic              arm_free_i,
  input  logic              stop_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              trig_hit_o,
  output logic [AW:0]       count_o,
  output logic              done_o
);
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_LEN  = 3'd5;

  logic [N_MATCH-1:0] hit, men;
  ctrl_t              ctrl_q;
  logic [LEN_W-1:0]   len_q;
  logic               we, wait_st, clr;
  logic [DATA_W-1:0]  sample;

  for (genvar k = 0; k < N_MATCH; k++) begin : g_unit
    logic [TRIG_W-1:0] val_q;
    rel_e              rel_q;
    logic              en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q <= '0; rel_q <= REL_EQ; en_q <= 1'b0;
      end else if (cfg_we_i && cfg_addr_i == 3'(k)) begin
        val_q <= cfg_wdata_i[TRIG_W-1:0];
        rel_q <= rel_e'(cfg_wdata_i[TRIG_W +: 2]);
        en_q  <= cfg_wdata_i[TRIG_W+2];
      end
    end
    assign men[k] = en_q;
    ela_match_unit #(.TRIG_W(TRIG_W)) u_match (
      .trig_i(trig_i), .value_i(val_q), .rel_i(rel_q), .hit_o(hit[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; len_q <= LEN_W'(1);
    end else if (cfg_we_i) begin
      if (cfg_addr_i == A_CTRL) ctrl_q <= ctrl_t'(cfg_wdata_i[CTRL_W-1:0]);
      if (cfg_addr_i == A_LEN)  len_q  <= cfg_wdata_i;
    end
  end

  ela_trig_comb u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .wait_i(wait_st),
    .hit_i(hit), .en_i(men), .ctrl_i(ctrl_q), .trig_o(trig_hit_o)
  );

  ela_capture_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_trig_i(arm_trig_i), .arm_free_i(arm_free_i),
    .stop_i(stop_i), .fire_i(trig_hit_o), .nsamp_i(ctrl_q.nsamp), .len_i(len_q),
    .we_o(we), .wait_o(wait_st), .clr_o(clr), .ptr_o(count_o), .done_o(done_o)
  );

  assign sample = ctrl_q.store_trig ? DATA_W'(trig_i) : data_i;

  ela_sample_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk_i(clk_i), .we_i(we), .waddr_i(count_o[AW-1:0]), .wdata_i(sample),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  p_full_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == (AW+1)'(DEPTH) |-> done_o);
  p_free_store_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_free_i && !arm_trig_i && !stop_i) |=> (!stop_i && !arm_trig_i && !arm_free_i)
      |=> count_o == (AW+1)'(1));
endmodule

// File: tb/test_ela_capture.sv
`timescale 1ns/1ps
module test_ela_capture;
  localparam int DW = 8, TW = 8, DEPTH = 8, CW = 16, AW = 3;

  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [CW-1:0] cfg_wdata = 0;
  logic arm_trig = 0, arm_free = 0, stop = 0;
  logic [TW-1:0] trig = 0; logic [DW-1:0] data = 0;
  logic [AW-1:0] rd_addr = 0; logic [DW-1:0] rd_data;
  logic trig_hit, done; logic [AW:0] count;
  int checks = 0, fails = 0; bit finished = 0;

  always #2.5 clk = ~clk;

  ela_capture #(.DATA_W(DW), .TRIG_W(TW), .DEPTH(DEPTH), .CFG_W(CW)) i_ela_capture (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .arm_trig_i(arm_trig), .arm_free_i(arm_free), .stop_i(stop),
    .trig_i(trig), .data_i(data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .trig_hit_o(trig_hit), .count_o(count), .done_o(done));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask
  task automatic wr(input int a, input int d);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = CW'(d); step; cfg_we = 0;
  endtask
  task automatic cyc(input int t, input int d);
    trig = TW'(t); data = DW'(d); step;
  endtask
  task automatic arm(input bit free);
    if (free) arm_free = 1; else arm_trig = 1;
    step; arm_free = 0; arm_trig = 0;
  endtask
  task automatic rd_chk(input string req, input int a, input int exp);
    rd_addr = AW'(a); #1; chk(req, int'(rd_data), exp);
  endtask
  function automatic int unit_word(int v, int r, int e);
    return v | (r << TW) | (e << (TW + 2));
  endfunction
  function automatic bit rel_hit(int t, int v, int r);
    case (r)
      0: return t == v;
      1: return t != v;
      2: return t < v;
      default: return t > v;
    endcase
  endfunction

  initial begin
    #(5ns * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v[4], r[4], e[4], t, use_or, inv, andr, orr, expv, exp_d[8];
    void'($urandom(32'd2024));
    #12 rst_ni = 1; step;
    chk("R8 reset count", int'(count), 0);
    chk("R8 reset done", int'(done), 0);

    // R1 R2: random flat-mode trigger
    for (int it = 0; it < 200; it++) begin
      for (int u = 0; u < 4; u++) begin
        v[u] = $urandom_range(0, 3); r[u] = $urandom_range(0, 3); e[u] = $urandom_range(0, 1);
        wr(u, unit_word(v[u], r[u], e[u]));
      end
      use_or = $urandom_range(0, 1); inv = $urandom_range(0, 1);
      wr(4, (use_or << 1) | (inv << 2));
      t = $urandom_range(0, 3); trig = TW'(t); #1;
      andr = 1; orr = 0;
      for (int u = 0; u < 4; u++) if (e[u] != 0) begin
        andr &= int'(rel_hit(t, v[u], r[u])); orr |= int'(rel_hit(t, v[u], r[u]));
      end
      expv = (use_or != 0 ? orr : andr) ^ inv;
      chk("R1 R2 flat trigger", int'(trig_hit), expv);
    end

    // R4: window mode, length 3
    wr(0, unit_word(8'h55, 0, 1));
    for (int u = 1; u < 4; u++) wr(u, 0);
    wr(4, 0); wr(5, 3);
    arm(0);
    chk("R8 arm clears count", int'(count), 0);
    cyc(0, 10); cyc(0, 11);
    chk("R4 no store before trigger", int'(count), 0);
    cyc(8'h55, 12);
    chk("R4 firing cycle stored", int'(count), 1);
    cyc(8'h55, 13); cyc(0, 14);
    chk("R4 window count", int'(count), 3);
    chk("R4 window done", int'(done), 1);
    cyc(8'h55, 15);
    chk("R4 nothing after window", int'(count), 3);
    rd_chk("R10 window s0", 0, 12); rd_chk("R10 window s1", 1, 13); rd_chk("R10 window s2", 2, 14);

    // R5 R6: N-samples mode, length 3, clipped at depth 8
    wr(4, 8'h08); wr(5, 3);
    arm(0);
    chk("R8 rearm done cleared", int'(done), 0);
    cyc(8'h55, 20); cyc(8'h55, 21); cyc(0, 22); cyc(0, 23);
    chk("R5 retrigger in run ignored", int'(count), 3);
    chk("R5 waits after run", int'(done), 0);
    cyc(8'h55, 24); cyc(0, 25); cyc(0, 26); cyc(8'h55, 27); cyc(0, 28);
    chk("R6 full count", int'(count), 8);
    chk("R6 full done", int'(done), 1);
    cyc(8'h55, 29);
    chk("R6 never exceeds depth", int'(count), 8);
    exp_d = '{20, 21, 22, 24, 25, 26, 27, 28};
    for (int k = 0; k < 8; k++) rd_chk("R10 nsamp order", k, exp_d[k]);

    // R3: three-level sequencer, units 0->1->2, enables off
    wr(0, unit_word(8'hA1, 0, 0)); wr(1, unit_word(8'hB2, 0, 0)); wr(2, unit_word(8'hC3, 0, 0));
    wr(4, 1 | (2 << 5) | (0 << 7) | (1 << 9) | (2 << 11)); wr(5, 1);
    arm(0);
    trig = 8'hC3; #1;
    chk("R3 no fire out of order", int'(trig_hit), 0);
    cyc(8'hC3, 30); cyc(8'hA1, 31); cyc(8'hC3, 32); cyc(8'hB2, 33);
    chk("R3 nothing stored before last level", int'(count), 0);
    trig = 8'hC3; data = 34; #1;
    chk("R3 fire at last level", int'(trig_hit), 1);
    step;
    chk("R3 single sample stored", int'(count), 1);
    rd_chk("R3 stored sample", 0, 34);

    // R7: stop during free capture
    wr(4, 0);
    arm(1);
    cyc(0, 40); cyc(0, 41); cyc(0, 42);
    chk("R8 free stores each cycle", int'(count), 3);
    stop = 1; data = 43; step; stop = 0;
    chk("R7 stop count", int'(count), 3);
    chk("R7 stop done", int'(done), 1);
    cyc(0, 44);
    chk("R7 no store after stop", int'(count), 3);

    // R9: store trigger vector
    wr(4, 8'h10);
    arm(1);
    for (int k = 0; k < 8; k++) cyc(8'h70 + k, 8'hEE);
    chk("R9 buffer full", int'(done), 1);
    for (int k = 0; k < 8; k++) rd_chk("R9 trigger stored", k, 8'h70 + k);

    arm(0);
    chk("R8 arm clears after full", int'(count), 0);
    chk("R8 arm clears done", int'(done), 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule